// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns an operand description into a memory address for a segmented processor that runs either in a 32-bit mode or in a 16-bit legacy mode. For each request it adds up to three terms: an optional base register, an optional index register multiplied by 1, 2, 4 or 8, and a signed displacement. The offset wraps to the width of the active mode. The unit then chooses one of four segments and forms the physical address as the segment value shifted left by four bits plus the offset. It also flags register and scale choices that the active mode forbids.

The segment comes from the kind of access. Code fetches, stack pushes and pops, and string destinations each use a fixed segment. Other data accesses use the stack segment when the frame pointer is the base, and the data segment otherwise. An explicit override can replace that choice for ordinary data accesses. The caller supplies all eight register values and all four segment values in parallel. The result is registered and appears one clock after a request strobe.

Top module: `eagu_top`

## Requirements
- R1: In 32-bit mode the offset is (base + (index << scale_code) + displacement) mod 2^32. A term whose enable is low contributes zero. scale_code 0..3 selects a factor of 1, 2, 4 or 8. The displacement is two's complement. Register codes are 0..7 = AX, CX, DX, BX, SP, BP, SI, DI.
- R2: In legacy mode (legacy=1) the offset is the same sum taken modulo 2^16, so bits 31..16 of the offset are zero.
- R3: The physical address (33 bits) is the selected segment value times 16 plus the zero-extended offset. seg_flat slot k (bits 16k+15..16k) holds the value of segment code k.
- R4: A code fetch (ref_kind=3) always selects segment code 1 (code), whatever the override inputs say.
- R5: A stack push or pop (ref_kind=1) selects segment code 2 (stack), and the override is ignored.
- R6: A string destination (ref_kind=2) selects segment code 0 (extra), and the override is ignored.
- R7: A data access (ref_kind=0) selects segment code 2 when the base is enabled and is BP (code 5), and segment code 3 (data) otherwise. When ovr_en=1, ovr_seg replaces this choice.
- R8: In 32-bit mode any register may be the base. An enabled index of SP (code 4) raises illegal.
- R9: In legacy mode illegal is raised when an enabled base is neither BX nor BP, when an enabled index is neither SI nor DI, or when scale_code is not 0.
- R10: out_vld equals in_vld delayed by one clock. After synchronous reset, out_vld, offset, seg_code, phys_addr and illegal are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Request strobe |
| gpr_flat | input | 256 | Eight 32-bit register values, register k at bits 32k+31..32k |
| seg_flat | input | 64 | Four 16-bit segment values, code k at bits 16k+15..16k |
| base_en | input | 1 | Base term present |
| base_sel | input | 3 | Base register code |
| idx_en | input | 1 | Index term present |
| idx_sel | input | 3 | Index register code |
| scale_code | input | 2 | Index shift amount (factor 1, 2, 4, 8) |
| disp | input | 32 | Signed displacement |
| ref_kind | input | 2 | 0 data, 1 stack push/pop, 2 string destination, 3 code fetch |
| ovr_en | input | 1 | Segment override present |
| ovr_seg | input | 2 | Override segment code |
| legacy | input | 1 | 16-bit legacy mode |
| out_vld | output | 1 | Result strobe |
| offset | output | 32 | Effective offset |
| seg_code | output | 2 | Selected segment code |
| phys_addr | output | 33 | Physical address |
| illegal | output | 1 | Forbidden register or scale combination |

## Verification
Two rules can apply to the same request. The first is the default that sends a BP-based data access to the stack segment. The second is the explicit override, which must win over that default. The bench sends data accesses with BP as base, both with and without ovr_en. It checks the segment code and also the physical address, which must use the override segment's value. A second case mixes legacy offset wrap with an illegal register choice. In that request the wrapped offset must still be correct while the flag is set.

// File: rtl/eagu_pkg.sv
package eagu_pkg;

    localparam int DW        = 32;   // offset / register width
    localparam int SW        = 16;   // segment register width
    localparam int LW        = 16;   // legacy offset width
    localparam int NREG      = 8;    // general registers
    localparam int NSEG      = 4;    // segment registers
    localparam int SEG_SHIFT = 4;    // segment paragraph shift
    localparam int RSW       = $clog2(NREG);
    localparam int PW        = DW + 1;

    typedef enum logic [1:0] {
        SEG_EXTRA = 2'd0,
        SEG_CODE  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_DATA  = 2'd3
    } seg_e;

    typedef enum logic [1:0] {
        REF_DATA   = 2'd0,
        REF_STACK  = 2'd1,
        REF_STRDST = 2'd2,
        REF_FETCH  = 2'd3
    } ref_e;

    localparam logic [RSW-1:0] RG_SP = 3'd4;
    localparam logic [RSW-1:0] RG_BX = 3'd3;
    localparam logic [RSW-1:0] RG_BP = 3'd5;
    localparam logic [RSW-1:0] RG_SI = 3'd6;
    localparam logic [RSW-1:0] RG_DI = 3'd7;

    typedef struct packed {
        logic [DW-1:0] off;
        seg_e          seg;
        logic [PW-1:0] pa;
        logic          bad;
    } ea_res_t;

    function automatic logic [DW-1:0] scale_term(input logic [DW-1:0] v, input logic [1:0] code);
        return v << code;
    endfunction

endpackage

// File: rtl/eagu_offset.sv
module eagu_offset
    import eagu_pkg::*;
#(
    parameter int W   = DW,
    parameter int NR  = NREG,
    parameter int LWD = LW
) (
    input  logic [NR*W-1:0]        gpr,
    input  logic                   base_en,
    input  logic [$clog2(NR)-1:0]  base_sel,
    input  logic                   idx_en,
    input  logic [$clog2(NR)-1:0]  idx_sel,
    input  logic [1:0]             scale,
    input  logic [W-1:0]           disp,
    input  logic                   legacy,
    output logic [W-1:0]           off
);
    logic [W-1:0] base_v, idx_v, sum;

    always_comb begin
        base_v = base_en ? gpr[base_sel*W +: W] : '0;
        idx_v  = idx_en  ? gpr[idx_sel*W  +: W] : '0;
        sum    = base_v + scale_term(idx_v, scale) + disp;
    end

    generate
        if (LWD < W) begin : g_wrap
            assign off = legacy ? {{(W-LWD){1'b0}}, sum[LWD-1:0]} : sum;
        end else begin : g_full
            assign off = sum;
        end
    endgenerate
endmodule

// File: rtl/eagu_segsel.sv
module eagu_segsel
    import eagu_pkg::*;
(
    input  ref_e             kind,
    input  logic             base_en,
    input  logic [RSW-1:0]   base_sel,
    input  logic             ovr_en,
    input  seg_e             ovr_seg,
    output seg_e             seg
);
    seg_e dflt;

    always_comb begin
        dflt = (base_en && base_sel == RG_BP) ? SEG_STACK : SEG_DATA;
        unique case (kind)
            REF_FETCH:  seg = SEG_CODE;
            REF_STACK:  seg = SEG_STACK;
            REF_STRDST: seg = SEG_EXTRA;
            default:    seg = ovr_en ? ovr_seg : dflt;
        endcase
    end
endmodule

// File: rtl/eagu_check.sv
module eagu_check
    import eagu_pkg::*;
(
    input  logic             legacy,
    input  logic             base_en,
    input  logic [RSW-1:0]   base_sel,
    input  logic             idx_en,
    input  logic [RSW-1:0]   idx_sel,
    input  logic [1:0]       scale,
    output logic             bad
);
    logic leg_base_bad, leg_idx_bad, wide_idx_bad;

    always_comb begin
        leg_base_bad = base_en && (base_sel != RG_BX) && (base_sel != RG_BP);
        leg_idx_bad  = idx_en  && (idx_sel  != RG_SI) && (idx_sel  != RG_DI);
        wide_idx_bad = idx_en  && (idx_sel == RG_SP);
        bad = legacy ? (leg_base_bad || leg_idx_bad || (scale != 2'd0)) : wide_idx_bad;
    end
endmodule

// File: rtl/eagu_top.sv
module eagu_top
    import eagu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_vld,
    input  logic [NREG*DW-1:0]   gpr_flat,
    input  logic [NSEG*SW-1:0]   seg_flat,
    input  logic                 base_en,
    input  logic [RSW-1:0]       base_sel,
    input  logic                 idx_en,
    input  logic [RSW-1:0]       idx_sel,
    input  logic [1:0]           scale_code,
    input  logic [DW-1:0]        disp,
    input  logic [1:0]           ref_kind,
    input  logic                 ovr_en,
    input  logic [1:0]           ovr_seg,
    input  logic                 legacy,
    output logic                 out_vld,
    output logic [DW-1:0]        offset,
    output logic [1:0]           seg_code,
    output logic [PW-1:0]        phys_addr,
    output logic                 illegal
);
    logic [DW-1:0] off_c;
    seg_e          seg_c;
    logic          bad_c;
    logic [SW-1:0] seg_val;
    ea_res_t       res_c, res_q;
    logic          vld_q;

    eagu_offset #(.W(DW), .NR(NREG), .LWD(LW)) u_off (
        .gpr(gpr_flat), .base_en(base_en), .base_sel(base_sel),
        .idx_en(idx_en), .idx_sel(idx_sel), .scale(scale_code),
        .disp(disp), .legacy(legacy), .off(off_c)
    );

    eagu_segsel u_seg (
        .kind(ref_e'(ref_kind)), .base_en(base_en), .base_sel(base_sel),
        .ovr_en(ovr_en), .ovr_seg(seg_e'(ovr_seg)), .seg(seg_c)
    );

    eagu_check u_chk (
        .legacy(legacy), .base_en(base_en), .base_sel(base_sel),
        .idx_en(idx_en), .idx_sel(idx_sel), .scale(scale_code), .bad(bad_c)
    );

    always_comb begin
        seg_val   = seg_flat[seg_c*SW +: SW];
        res_c.off = off_c;
        res_c.seg = seg_c;
        res_c.pa  = (PW'(seg_val) << SEG_SHIFT) + PW'(off_c);
        res_c.bad = bad_c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= in_vld;
            if (in_vld) res_q <= res_c;
        end
    end

    assign out_vld   = vld_q;
    assign offset    = res_q.off;
    assign seg_code  = res_q.seg;
    assign phys_addr = res_q.pa;
    assign illegal   = res_q.bad;

    // R10
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_vld == $past(in_vld)));

    // R2
    legacy_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (out_vld && $past(legacy)) |-> (offset[DW-1:LW] == '0));

    // R4
    fetch_code_chk: assert property (@(posedge clk) disable iff (rst)
        (out_vld && $past(ref_kind) == 2'd3) |-> (seg_code == 2'd1));

    // R6
    strdst_extra_chk: assert property (@(posedge clk) disable iff (rst)
        (out_vld && $past(ref_kind) == 2'd2) |-> (seg_code == 2'd0));

    // R9
    legacy_scale_chk: assert property (@(posedge clk) disable iff (rst)
        (out_vld && $past(legacy && scale_code != 2'd0)) |-> illegal);

    // R8
    sp_index_chk: assert property (@(posedge clk) disable iff (rst)
        (out_vld && $past(!legacy && idx_en && idx_sel == 3'd4)) |-> illegal);
endmodule

// File: tb/tb_eagu_top.sv
module tb_eagu_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        in_vld = 0, base_en = 0, idx_en = 0, ovr_en = 0, legacy = 0;
    logic [2:0]  base_sel = 0, idx_sel = 0;
    logic [1:0]  scale_code = 0, ref_kind = 0, ovr_seg = 0;
    logic [31:0] disp = 0;
    logic [31:0] regs [8];
    logic [15:0] segv [4];
    logic [255:0] gpr_flat;
    logic [63:0]  seg_flat;
    logic        out_vld, illegal;
    logic [31:0] offset;
    logic [1:0]  seg_code;
    logic [32:0] phys_addr;

    always_comb begin
        for (int k = 0; k < 8; k++) gpr_flat[k*32 +: 32] = regs[k];
        for (int k = 0; k < 4; k++) seg_flat[k*16 +: 16] = segv[k];
    end

    eagu_top dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .gpr_flat(gpr_flat), .seg_flat(seg_flat),
        .base_en(base_en), .base_sel(base_sel), .idx_en(idx_en), .idx_sel(idx_sel),
        .scale_code(scale_code), .disp(disp), .ref_kind(ref_kind), .ovr_en(ovr_en),
        .ovr_seg(ovr_seg), .legacy(legacy), .out_vld(out_vld), .offset(offset),
        .seg_code(seg_code), .phys_addr(phys_addr), .illegal(illegal)
    );

    typedef struct {
        logic [31:0] off;
        logic [1:0]  seg;
        logic [32:0] pa;
        logic        bad;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int compared = 0, mismatched = 0;
    bit done = 0;

    function automatic exp_t model(bit be, logic [2:0] bs, bit ie, logic [2:0] is,
                                   logic [1:0] sc, logic [31:0] d, logic [1:0] rk,
                                   bit oe, logic [1:0] os, bit lg, string tag);
        exp_t e;
        logic [31:0] b, x, s;
        b = be ? regs[bs] : 32'h0;
        x = ie ? regs[is] : 32'h0;
        s = b + x * (32'd1 << sc) + d;
        e.off = lg ? {16'h0, s[15:0]} : s;
        case (rk)
            2'd3:    e.seg = 2'd1;
            2'd1:    e.seg = 2'd2;
            2'd2:    e.seg = 2'd0;
            default: e.seg = oe ? os : ((be && bs == 3'd5) ? 2'd2 : 2'd3);
        endcase
        e.pa  = {13'h0, segv[e.seg], 4'h0} + {1'b0, e.off};
        if (lg) e.bad = (sc != 0) || (be && bs != 3'd3 && bs != 3'd5) || (ie && is != 3'd6 && is != 3'd7);
        else    e.bad = ie && is == 3'd4;
        e.tag = tag;
        return e;
    endfunction

    task automatic send(bit be, logic [2:0] bs, bit ie, logic [2:0] is, logic [1:0] sc,
                        logic [31:0] d, logic [1:0] rk, bit oe, logic [1:0] os, bit lg, string tag);
        @(negedge clk);
        base_en = be; base_sel = bs; idx_en = ie; idx_sel = is; scale_code = sc;
        disp = d; ref_kind = rk; ovr_en = oe; ovr_seg = os; legacy = lg; in_vld = 1;
        exp_q.push_back(model(be, bs, ie, is, sc, d, rk, oe, os, lg, tag));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld = 0;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !done && out_vld) begin
            compared++;
            if (exp_q.size() == 0) begin
                mismatched++;
                $display("FAIL R10: out_vld=1 with no request pending (expected out_vld=0)");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (offset !== e.off || seg_code !== e.seg || phys_addr !== e.pa || illegal !== e.bad) begin
                    mismatched++;
                    $display("FAIL %s: off=%h seg=%0d pa=%h bad=%b expected off=%h seg=%0d pa=%h bad=%b",
                             e.tag, offset, seg_code, phys_addr, illegal, e.off, e.seg, e.pa, e.bad);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            mismatched++;
            $display("FAIL watchdog: run did not finish (expected completion)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        regs[0] = 32'h0000_1000; regs[1] = 32'h0000_0006; regs[2] = 32'h0000_0002;
        regs[3] = 32'h0001_FFF0; regs[4] = 32'h0000_8000; regs[5] = 32'h0000_000C;
        regs[6] = 32'h0000_0030; regs[7] = 32'hFFFF_FFF8;
        segv[0] = 16'h2000; segv[1] = 16'hF000; segv[2] = 16'h3000; segv[3] = 16'h1234;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R10: reset state
        compared++;
        if (out_vld !== 0 || offset !== 0 || seg_code !== 0 || phys_addr !== 0 || illegal !== 0) begin
            mismatched++;
            $display("FAIL R10: reset vld=%b off=%h seg=%0d pa=%h bad=%b expected all zero",
                     out_vld, offset, seg_code, phys_addr, illegal);
        end
        // R1 R3: displacement only, data segment
        send(0, 0, 0, 0, 0, 32'd22, 0, 0, 0, 0, "R1");
        // R1: base only (BX) plus displacement
        send(1, 3, 0, 0, 0, 32'd4, 0, 0, 0, 0, "R1");
        // R1: negative displacement, offset below base
        send(1, 0, 0, 0, 0, 32'hFFFF_FFFA, 0, 0, 0, 0, "R1");
        // R1: scaled index 2, 4, 8
        send(1, 3, 1, 1, 1, 32'd4, 0, 0, 0, 0, "R1");
        send(1, 3, 1, 2, 2, 32'd10, 0, 0, 0, 0, "R1");
        send(0, 0, 1, 1, 3, 32'd0, 0, 0, 0, 0, "R1");
        // R1: 32-bit wrap
        send(1, 7, 0, 0, 0, 32'd16, 0, 0, 0, 0, "R1");
        // R7: BP base defaults to stack
        send(1, 5, 1, 7, 0, 32'd10, 0, 0, 0, 0, "R7");
        // R7: override beats BP default (same cycle conflict)
        send(1, 5, 0, 0, 0, 32'd2, 0, 1, 0, 0, "R7");
        // R7: override on plain data
        send(1, 3, 0, 0, 0, 32'd0, 0, 1, 2, 0, "R7");
        // R4: fetch ignores override
        send(0, 0, 0, 0, 0, 32'h100, 3, 1, 3, 0, "R4");
        // R5: push/pop stack, override ignored
        send(1, 4, 0, 0, 0, 32'hFFFF_FFFE, 1, 1, 3, 0, "R5");
        // R6: string destination extra, override ignored
        send(1, 7, 0, 0, 0, 32'd8, 2, 1, 3, 0, "R6");
        // R8: SP as index illegal, SP as base legal
        send(1, 0, 1, 4, 0, 32'd0, 0, 0, 0, 0, "R8");
        send(1, 4, 1, 6, 0, 32'd0, 0, 0, 0, 0, "R8");
        // R2: legacy BX+SI with wrap, legal
        send(1, 3, 1, 6, 0, 32'd0, 0, 0, 0, 1, "R2");
        // R2 R9: legacy wrap with illegal base AX
        send(1, 0, 1, 7, 0, 32'd4, 0, 0, 0, 1, "R9");
        // R9: legacy scale illegal, legacy index illegal
        send(1, 5, 1, 6, 1, 32'd0, 0, 0, 0, 1, "R9");
        send(1, 3, 1, 1, 0, 32'd0, 0, 0, 0, 1, "R9");
        idle(2);
        // back-to-back random mix
        for (int i = 0; i < 80; i++) begin
            logic [31:0] r;
            r = $urandom;
            send(r[0], r[3:1], r[4], r[7:5], r[9:8], $urandom, r[11:10], r[12], r[14:13], r[15], "RND");
            if (r[16]) idle(1);
        end
        idle(4);
        compared++;
        if (exp_q.size() != 0) begin
            mismatched++;
            $display("FAIL R10: %0d results missing (expected 0)", exp_q.size());
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule